// File: doc/BRIEF.md
# SDLC Frame Transmitter

This block sends bit-oriented synchronous frames on a single serial line, one line bit per clock. A CPU or DMA engine writes bytes into a one-entry holding buffer. The block shifts each byte out least significant bit first and inserts a zero after every run of five ones. Each frame is wrapped in 0x7E flags. While the transmitter is enabled and has no data, it sends flags back to back. While it is disabled, the line sits at mark (constant 1).

A frame ends on its own when the buffer runs dry at the end of a data character (underrun). An end-of-message latch then picks how the frame closes. If the latch is set, which is its state after reset, only a flag follows. If software has cleared the latch during the frame, the inverted CRC-16 goes out first and is then followed by flags. Starting the CRC sets the latch again and raises an external/status interrupt pulse.

Further controls let software abort a frame and drop the transmitter to a marking line. Both act at a character boundary.

Top module: `sdlc_framer_tx`

States: `ST_MARK` (line held at 1), `ST_FLAG` (flag in the shifter), `ST_DATA` (data byte in the shifter), `ST_CRC` (16 CRC bits in the shifter), `ST_ABORT` (eight ones in the shifter). The state changes only at a character boundary, that is, when the shifter has no bits left and owes no stuffed zero. The transitions are:

- Enable off, from any state: go to `ST_MARK`.
- Abort pending, from any state: go to `ST_ABORT`.
- Buffer full, from `ST_FLAG` or `ST_DATA`: go to `ST_DATA` (data load).
- Underrun with the latch clear, from `ST_DATA`: go to `ST_CRC`.
- Underrun with the latch set, from `ST_DATA`: go to `ST_FLAG`.
- CRC done, from `ST_CRC`: go to `ST_FLAG`.
- Start-up, from `ST_MARK` or `ST_ABORT`: go to `ST_FLAG`.
- Idle, from `ST_FLAG` with the buffer empty: stay in `ST_FLAG`.

## Requirements
- R1: After reset, `txd` is 1, `buf_empty` is 1, `eom_latch` is 1 and both interrupt outputs are 0. With `tx_en` low, the line stays at 1.
- R2: While enabled, the line carries flags (0x7E, sent LSB first) between frames. A frame is an opening flag, its data bytes sent LSB first in write order, and a closing flag.
- R3: Inside data and CRC bits, a 0 is inserted after every five consecutive 1s, so a receiver that drops those zeros recovers the bytes exactly. Flags and abort characters get no insertion.
- R4: If `eom_latch` is 1 at underrun, the frame closes with a flag only. No CRC is sent and `ext_irq` does not pulse.
- R5: If `eom_latch` is 0 at underrun, the block sends the one's complement of a CRC-16 before the flags. The CRC uses the reflected polynomial 0x8408, is preset to 0xFFFF at each frame start and covers every data byte. It is sent low byte first, each byte LSB first. `ext_irq` pulses for one cycle in the cycle the first CRC bit is on `txd`, and from that cycle `eom_latch` reads 1. A one-cycle pulse on `clr_eom` clears the latch.
- R6: `buf_empty` is 0 for the whole time CRC bits are on the line. A write (`wr_valid`) in a cycle where `buf_empty` is 0 is ignored.
- R7: `tx_irq` pulses once for each byte moved from the buffer into the shifter, and once when the first flag after a CRC starts.
- R8: When `tx_en` falls, the character in progress completes and the line then marks. A byte waiting in the buffer stays there, and after re-enable it is sent in a new frame behind an opening flag.
- R9: If `tx_en` falls while CRC is being sent, all 16 CRC bits (plus any inserted zeros) complete before the line marks.
- R10: `abort_cmd` (accepted while enabled) ends the current frame at the next character boundary with eight 1s, sets `eom_latch`, and flags then resume. The frame is never closed as valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one line bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmitter enable |
| wr_valid | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte to write |
| clr_eom | input | 1 | Clears the end-of-message latch |
| abort_cmd | input | 1 | Requests a frame abort |
| txd | output | 1 | Serial line output |
| buf_empty | output | 1 | Holding buffer can take a byte |
| eom_latch | output | 1 | End-of-message latch state |
| tx_irq | output | 1 | Transmit interrupt pulse |
| ext_irq | output | 1 | External/status interrupt pulse (CRC start) |

## Verification
A line bit chosen at a clock edge is visible on `txd` in the sample that follows that edge. A write shows as `buf_empty` low in the very next sample. `ext_irq` and the first CRC bit appear in the same sample, and `buf_empty` then stays low for exactly 16 samples plus one per inserted zero. `tx_irq` appears one sample after the byte transfer. The bench samples every output on the falling edge and feeds each sample to a line decoder, which removes inserted zeros, finds flags and aborts, and compares each finished frame with the byte list the driver queued. Frame contents are therefore checked at the time they complete, not at a fixed delay. Interrupt counts and the length of the CRC window are read in the same falling-edge samples.

// File: rtl/sdlc_tx_pkg.sv
package sdlc_tx_pkg;

    // Kind of character currently held in the output shifter
    typedef enum logic [2:0] {
        ST_MARK,
        ST_FLAG,
        ST_DATA,
        ST_CRC,
        ST_ABORT
    } tx_state_e;

endpackage

// File: rtl/sdlc_tx_crc.sv
module sdlc_tx_crc #(
    parameter int                DATA_W = 8,
    parameter int                CRC_W  = 16,
    parameter logic [CRC_W-1:0]  POLY   = 16'h8408,
    parameter logic [CRC_W-1:0]  INIT   = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              upd,
    input  logic [DATA_W-1:0] din,
    output logic [CRC_W-1:0]  crc_q
);

    // Reflected CRC over one byte, LSB first
    function automatic logic [CRC_W-1:0] step(input logic [CRC_W-1:0] c_in,
                                              input logic [DATA_W-1:0] d);
        logic [CRC_W-1:0] c;
        c = c_in;
        for (int i = 0; i < DATA_W; i++) begin
            if (c[0] ^ d[i]) c = (c >> 1) ^ POLY;
            else             c = c >> 1;
        end
        return c;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n)   crc_q <= INIT;
        else if (upd) crc_q <= step(start ? INIT : crc_q, din);
    end

endmodule

// File: rtl/sdlc_tx_shifter.sv
module sdlc_tx_shifter #(
    parameter int CHAR_W    = 16,
    parameter int LEN_W     = 5,
    parameter int STUFF_RUN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CHAR_W-1:0] ld_char,
    input  logic [LEN_W-1:0]  ld_len,
    input  logic              ld_stuff,
    output logic              need,
    output logic              txd
);

    localparam int RUN_W = $clog2(STUFF_RUN + 1);

    logic [CHAR_W-1:0] sh;
    logic [LEN_W-1:0]  left;
    logic [RUN_W-1:0]  ones;
    logic              stf;
    logic              stuff_now;

    assign stuff_now = (ones == RUN_W'(STUFF_RUN));
    // A new character is taken every cycle this is high
    assign need      = (left == '0) && !stuff_now;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '0;
            left <= '0;
            ones <= '0;
            stf  <= 1'b0;
            txd  <= 1'b1;
        end else if (stuff_now) begin
            txd  <= 1'b0;
            ones <= '0;
        end else if (left != '0) begin
            txd  <= sh[0];
            sh   <= sh >> 1;
            left <= left - LEN_W'(1);
            ones <= (stf && sh[0]) ? ones + RUN_W'(1) : '0;
        end else begin
            txd  <= ld_char[0];
            sh   <= ld_char >> 1;
            left <= ld_len - LEN_W'(1);
            stf  <= ld_stuff;
            ones <= (ld_stuff && ld_char[0]) ? ones + RUN_W'(1) : '0;
        end
    end

    // R3: the run counter never passes the insertion threshold
    p_run_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ones <= RUN_W'(STUFF_RUN));

endmodule

// File: rtl/sdlc_framer_tx.sv
module sdlc_framer_tx
    import sdlc_tx_pkg::*;
#(
    parameter int               DATA_W    = 8,
    parameter int               CRC_W     = 16,
    parameter logic [CRC_W-1:0] CRC_POLY  = 16'h8408,
    parameter logic [CRC_W-1:0] CRC_INIT  = 16'hFFFF,
    parameter logic [DATA_W-1:0] FLAG_CHAR = 8'h7E,
    parameter int               STUFF_RUN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_eom,
    input  logic              abort_cmd,
    output logic              txd,
    output logic              buf_empty,
    output logic              eom_latch,
    output logic              tx_irq,
    output logic              ext_irq
);

    localparam int CHAR_W = (CRC_W > DATA_W) ? CRC_W : DATA_W;
    localparam int LEN_W  = $clog2(CHAR_W + 1);

    tx_state_e         state, nxt;
    logic              buf_full;
    logic [DATA_W-1:0] buf_q;
    logic              eom_q;
    logic              abort_pend;
    logic              need;
    logic [CHAR_W-1:0] ld_char;
    logic [LEN_W-1:0]  ld_len;
    logic              ld_stuff;
    logic              take_buf, go_crc, go_abort, post_crc_flag;
    logic [CRC_W-1:0]  crc_q;

    assign buf_empty = !buf_full && (state != ST_CRC);
    assign eom_latch = eom_q;

    sdlc_tx_crc #(
        .DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)
    ) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .start (state == ST_FLAG),
        .upd   (take_buf),
        .din   (buf_q),
        .crc_q (crc_q)
    );

    sdlc_tx_shifter #(
        .CHAR_W(CHAR_W), .LEN_W(LEN_W), .STUFF_RUN(STUFF_RUN)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_char  (ld_char),
        .ld_len   (ld_len),
        .ld_stuff (ld_stuff),
        .need     (need),
        .txd      (txd)
    );

    // Next character choice at each boundary
    always_comb begin
        nxt           = state;
        ld_char       = CHAR_W'(1);
        ld_len        = LEN_W'(1);
        ld_stuff      = 1'b0;
        take_buf      = 1'b0;
        go_crc        = 1'b0;
        go_abort      = 1'b0;
        post_crc_flag = 1'b0;
        if (need) begin
            if (!tx_en) begin
                nxt = ST_MARK;
            end else if (abort_pend) begin
                nxt      = ST_ABORT;
                ld_char  = CHAR_W'({DATA_W{1'b1}});
                ld_len   = LEN_W'(DATA_W);
                go_abort = 1'b1;
            end else begin
                unique case (state)
                    ST_FLAG, ST_DATA: begin
                        if (buf_full) begin
                            nxt      = ST_DATA;
                            ld_char  = CHAR_W'(buf_q);
                            ld_len   = LEN_W'(DATA_W);
                            ld_stuff = 1'b1;
                            take_buf = 1'b1;
                        end else if (state == ST_DATA && !eom_q) begin
                            nxt      = ST_CRC;
                            ld_char  = CHAR_W'(~crc_q);
                            ld_len   = LEN_W'(CRC_W);
                            ld_stuff = 1'b1;
                            go_crc   = 1'b1;
                        end else begin
                            nxt     = ST_FLAG;
                            ld_char = CHAR_W'(FLAG_CHAR);
                            ld_len  = LEN_W'(DATA_W);
                        end
                    end
                    ST_CRC: begin
                        nxt           = ST_FLAG;
                        ld_char       = CHAR_W'(FLAG_CHAR);
                        ld_len        = LEN_W'(DATA_W);
                        post_crc_flag = 1'b1;
                    end
                    default: begin
                        nxt     = ST_FLAG;
                        ld_char = CHAR_W'(FLAG_CHAR);
                        ld_len  = LEN_W'(DATA_W);
                    end
                endcase
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_MARK;
        else        state <= nxt;
    end

    // Buffer, latch and interrupt outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_full   <= 1'b0;
            buf_q      <= '0;
            eom_q      <= 1'b1;
            abort_pend <= 1'b0;
            tx_irq     <= 1'b0;
            ext_irq    <= 1'b0;
        end else begin
            if (take_buf) begin
                buf_full <= 1'b0;
            end else if (wr_valid && buf_empty) begin
                buf_full <= 1'b1;
                buf_q    <= wr_data;
            end
            if (go_crc || go_abort) eom_q <= 1'b1;
            else if (clr_eom)       eom_q <= 1'b0;
            if (go_abort || (need && !tx_en)) abort_pend <= 1'b0;
            else if (abort_cmd && tx_en)      abort_pend <= 1'b1;
            tx_irq  <= take_buf || post_crc_flag;
            ext_irq <= go_crc;
        end
    end

    p_crc_sets_eom_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ext_irq |-> eom_latch);

    p_crc_blocks_buf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ext_irq |-> !buf_empty);

    p_irq_apart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_irq && ext_irq));

    p_mark_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (need && !tx_en) |=> txd);

    p_hold_buf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && buf_full) |=> (buf_full && $stable(buf_q)));

    p_abort_sets_eom_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (need && tx_en && abort_pend) |=> eom_latch);

endmodule

// File: tb/sdlc_framer_tx_tb.sv
module sdlc_framer_tx_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       clr_eom = 1'b0;
    logic       abort_cmd = 1'b0;
    logic       txd, buf_empty, eom_latch, tx_irq, ext_irq;

    always #10 clk = ~clk;  // 50 MHz

    sdlc_framer_tx u_dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_valid(wr_valid),
        .wr_data(wr_data), .clr_eom(clr_eom), .abort_cmd(abort_cmd),
        .txd(txd), .buf_empty(buf_empty), .eom_latch(eom_latch),
        .tx_irq(tx_irq), .ext_irq(ext_irq)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int n_txirq = 0;
    int n_ext   = 0;
    int n_abort = 0;
    int n_frames = 0;

    int         exp_len_q[$];
    logic [7:0] exp_byte_q[$];
    string      exp_tag_q[$];
    logic [7:0] cur[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_upd(input logic [15:0] c_in, input logic [7:0] d);
        logic [15:0] c;
        c = c_in;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ d[i]) c = (c >> 1) ^ 16'h8408;
            else             c = c >> 1;
        end
        return c;
    endfunction

    // ---- Line decoder (monitor side of the scoreboard) ----
    bit fb[$];
    int ones_run = 0;
    bit active = 1'b0;

    task automatic deliver();
        int nbits;
        int nbytes;
        int elen;
        string tag;
        nbits = fb.size() - 7;
        if (nbits <= 0) return;
        n_frames++;
        nbytes = nbits / 8;
        if (exp_len_q.size() == 0) begin
            chk(1'b0, "R2", "unexpected frame bytes", nbytes, 0);
            return;
        end
        elen = exp_len_q.pop_front();
        tag  = exp_tag_q.pop_front();
        chk((nbits % 8) == 0 && nbytes == elen, tag, "frame length bits", nbits, elen * 8);
        for (int k = 0; k < elen; k++) begin
            logic [7:0] got;
            logic [7:0] want;
            got = 8'h00;
            for (int i = 0; i < 8; i++)
                if (8 * k + i < nbits) got[i] = fb[8 * k + i];
            want = exp_byte_q.pop_front();
            chk(got == want, tag, $sformatf("frame byte %0d", k), got, want);
        end
    endtask

    task automatic rx_bit(input bit b);
        if (b) begin
            ones_run++;
            if (active) fb.push_back(1'b1);
            if (ones_run == 7) begin
                if (active) n_abort++;
                active = 1'b0;
                fb.delete();
            end
        end else begin
            if (ones_run == 5) begin
                ones_run = 0;
            end else if (ones_run == 6) begin
                if (active) deliver();
                fb.delete();
                active = 1'b1;
                ones_run = 0;
            end else begin
                ones_run = 0;
                if (active) fb.push_back(1'b0);
            end
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            rx_bit(txd);
            if (tx_irq) n_txirq++;
            if (ext_irq) begin
                n_ext++;
                chk(!buf_empty, "R6", "buf_empty while CRC starts", buf_empty, 0);
                chk(eom_latch, "R5", "eom latch at CRC start", eom_latch, 1);
            end
        end
    end

    // ---- Driver side ----
    task automatic wr_byte(input logic [7:0] d);
        while (!buf_empty) @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic send(input bit clr_first, input bit expect_it,
                        input bit with_crc, input string tag);
        logic [15:0] c;
        c = 16'hFFFF;
        if (expect_it) begin
            exp_len_q.push_back(cur.size() + (with_crc ? 2 : 0));
            exp_tag_q.push_back(tag);
            foreach (cur[i]) begin
                exp_byte_q.push_back(cur[i]);
                c = crc_upd(c, cur[i]);
            end
            if (with_crc) begin
                exp_byte_q.push_back(~c[7:0]);
                exp_byte_q.push_back(~c[15:8]);
            end
        end
        foreach (cur[i]) begin
            wr_byte(cur[i]);
            if (i == 0 && clr_first) begin
                clr_eom = 1'b1;
                @(negedge clk);
                clr_eom = 1'b0;
            end
        end
    endtask

    task automatic wait_done(input string tag);
        int t;
        t = 0;
        while (exp_len_q.size() != 0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        chk(exp_len_q.size() == 0, tag, "frames still pending", exp_len_q.size(), 0);
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int tx0, ext0, ab0, fr0, run, marks;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state and marking line while disabled
        chk(txd == 1'b1, "R1", "txd after reset", txd, 1);
        chk(buf_empty == 1'b1, "R1", "buf_empty after reset", buf_empty, 1);
        chk(eom_latch == 1'b1, "R1", "eom_latch after reset", eom_latch, 1);
        chk(!tx_irq && !ext_irq, "R1", "irqs after reset", tx_irq + ext_irq, 0);
        marks = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (txd) marks++;
        end
        chk(marks == 20, "R1", "mark samples while disabled", marks, 20);

        tx_en = 1'b1;
        repeat (30) @(negedge clk);

        // R2/R4: latch set after reset, frame closes with flag only
        tx0 = n_txirq; ext0 = n_ext;
        cur = '{8'h81, 8'h42, 8'hC3};
        send(1'b0, 1'b1, 1'b0, "R2");
        wait_done("R4");
        chk(n_ext == ext0, "R4", "ext_irq pulses on flag-only close", n_ext - ext0, 0);
        chk(eom_latch == 1'b1, "R4", "latch after flag-only close", eom_latch, 1);
        chk(n_txirq - tx0 == 3, "R7", "tx_irq pulses, 3 bytes no CRC", n_txirq - tx0, 3);

        // R5: latch cleared in frame, CRC appended
        tx0 = n_txirq; ext0 = n_ext;
        cur = '{8'h12, 8'h34, 8'h56};
        send(1'b1, 1'b1, 1'b1, "R5");
        wait_done("R5");
        chk(n_ext - ext0 == 1, "R5", "ext_irq pulses on CRC close", n_ext - ext0, 1);
        chk(eom_latch == 1'b1, "R5", "latch set again after CRC", eom_latch, 1);
        chk(n_txirq - tx0 == 4, "R7", "tx_irq pulses, 3 bytes + CRC", n_txirq - tx0, 4);

        // R3: long runs of ones need zero insertion
        cur = '{8'hFF, 8'hFF, 8'h7E, 8'h3E, 8'hF8};
        send(1'b1, 1'b1, 1'b1, "R3");
        wait_done("R3");

        // R6: second write while buffer full is ignored
        while (!buf_empty) @(negedge clk);
        exp_len_q.push_back(1); exp_tag_q.push_back("R6"); exp_byte_q.push_back(8'hA1);
        wr_valid = 1'b1; wr_data = 8'hA1;
        @(negedge clk);
        chk(buf_empty == 1'b0, "R6", "buf_empty after write", buf_empty, 0);
        wr_data = 8'hB2;
        @(negedge clk);
        wr_valid = 1'b0;
        wait_done("R6");

        // R10: abort a frame in progress
        ab0 = n_abort; fr0 = n_frames; ext0 = n_ext;
        cur = '{8'h11, 8'h22};
        send(1'b1, 1'b0, 1'b0, "R10");
        while (!buf_empty) @(negedge clk);
        abort_cmd = 1'b1;
        @(negedge clk);
        abort_cmd = 1'b0;
        repeat (80) @(negedge clk);
        chk(n_abort - ab0 >= 1, "R10", "abort seen on line", n_abort - ab0, 1);
        chk(n_frames == fr0, "R10", "frames delivered after abort", n_frames - fr0, 0);
        chk(n_ext == ext0, "R10", "ext_irq during aborted frame", n_ext - ext0, 0);
        chk(eom_latch == 1'b1, "R10", "latch after abort", eom_latch, 1);
        cur = '{8'h5C, 8'hE7};
        send(1'b1, 1'b1, 1'b1, "R10");
        wait_done("R10");

        // R8: disable with a byte waiting in the buffer
        cur = '{8'h0F, 8'hF0};
        send(1'b0, 1'b0, 1'b0, "R8");
        while (!buf_empty) @(negedge clk);
        wr_valid = 1'b1; wr_data = 8'h9D;
        @(negedge clk);
        wr_valid = 1'b0;
        tx_en = 1'b0;
        fr0 = n_frames;
        repeat (20) @(negedge clk);
        marks = 0;
        for (int i = 0; i < 20; i++) begin
            if (txd) marks++;
            @(negedge clk);
        end
        chk(marks == 20, "R8", "mark samples after disable", marks, 20);
        chk(buf_empty == 1'b0, "R8", "buffered byte held while disabled", buf_empty, 0);
        chk(n_frames == fr0, "R8", "cut frame delivered", n_frames - fr0, 0);
        exp_len_q.push_back(1); exp_tag_q.push_back("R8"); exp_byte_q.push_back(8'h9D);
        tx_en = 1'b1;
        wait_done("R8");

        // R9: disable during CRC, all CRC bits complete first
        ext0 = n_ext;
        cur = '{8'hA5, 8'h5A};
        send(1'b1, 1'b0, 1'b0, "R9");
        run = 0;
        while (!ext_irq && run < 200) begin
            @(negedge clk);
            run++;
        end
        tx_en = 1'b0;
        run = 0;
        while (!buf_empty && run < 40) begin
            run++;
            @(negedge clk);
        end
        chk(run >= 16 && run <= 19, "R9", "CRC window cycles after disable", run, 16);
        marks = 0;
        for (int i = 0; i < 10; i++) begin
            if (txd) marks++;
            @(negedge clk);
        end
        chk(marks == 10, "R9", "mark samples after CRC", marks, 10);
        chk(n_ext - ext0 == 1, "R9", "ext_irq pulses", n_ext - ext0, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule